// File: doc/BRIEF.md
# Multi-Channel Scanline Burst Fetcher

This block turns wakeups from four raster channels into memory burst requests through one shared datapath. A wakeup names a channel with a 2-bit ID, and that ID selects one bank of per-channel state. Each bank holds a running line offset, a signed remaining-burst count and the base address of the line being read. It also holds the count and 32-bit base for the next line, which a line sequencer preloads through a small write port. The running offset register carries two further pieces of state. Its two lowest bits always hold the channel's own ID. Its top bit is a begin-line flag: when set, the current line is finished and the next wakeup opens a new line.

Each accepted wakeup does exactly one of the following:
- issue one burst request and advance the offset;
- close the current line and tell the wake logic to stop requesting for that channel;
- open the next line, which normally issues its first burst in the same wakeup.

A wakeup that tries to open a line whose preloaded base is zero is trapped as a bad wakeup. The block sets a sticky per-channel bit and sends a shut-up command instead of fetching. After every action the block refuses wakeups for a fixed holdoff window.

Top module: `scanline_burst_fetcher`

## Requirements
- R1: After reset, `wake_ready` is 1, `req_valid`, `ctl_valid` and `bad_status` are 0. Every channel starts with its begin-line flag set, its remaining count at -1, its next count at -1 and its next base at zero. As a result, its first wakeup opens a line and reports a bad wakeup.
- R2: A wakeup on a channel whose count is non-negative raises `req_valid` with `req_addr` = line base + offset, where the offset's two low bits are read as zero. The offset then grows by 16 words and the count drops by one.
- R3: A wakeup on a channel whose count is negative and whose begin-line flag is clear does not issue a request. It sets the flag, decrements the count and pulses `ctl_valid` for one cycle with `ctl_code` = 1 (line done) and `ctl_chan` = the channel ID.
- R4: A wakeup on a channel whose count is negative and whose flag is set, with a nonzero next base, opens a line. The next base becomes the line base, the offset is reset to zero and the flag is cleared. The count is loaded from the next count before any other test. If that value is non-negative, a request at exactly the new base is issued in the same wakeup and the count becomes next count - 1.
- R5: If a line opens (as in R4) with a negative next count, no request is issued. The line closes at once with a `ctl_code` = 1 pulse, the flag set and the count at next count - 1.
- R6: If the next base is zero when a line would open, the wakeup is bad. Bit `bad_status[ID]` is set by OR and never cleared while out of reset. `ctl_valid` pulses with `ctl_code` = 2 (shut up). The count is loaded from the next count, the flag stays set and no request is issued.
- R7: The two low bits of every channel's offset always equal its ID (3, 2, 1, 0 for channels A to D). They are kept across fetches, line ends and line starts, and they never reach `req_addr`.
- R8: While `req_valid` is high without `req_ready`, `req_valid` and `req_addr` hold steady and `wake_ready` is low. The request drops in the cycle after the handshake.
- R9: After a request handshake or a `ctl_valid` pulse, `wake_ready` stays low for exactly GAP cycles (default 5).
- R10: A wakeup changes only the state of the channel it names. A preload write changes only the named channel's next count and next base, and takes effect at that channel's next line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_valid | input | 1 | Wakeup present |
| wake_chan | input | 2 | Channel ID of the wakeup |
| wake_ready | output | 1 | Wakeup accepted when high with wake_valid |
| cfg_we | input | 1 | Preload write strobe |
| cfg_chan | input | 2 | Channel ID for the preload |
| cfg_next_count | input | CW | Next line burst count minus one (signed) |
| cfg_next_base | input | BAW | Next line base address |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | BAW | Burst word address |
| ctl_valid | output | 1 | One-cycle command pulse to wake logic |
| ctl_chan | output | 2 | Channel ID the command applies to |
| ctl_code | output | 2 | 1 = line done, 2 = shut up |
| bad_status | output | 4 | Sticky bad-wakeup bit per channel ID |

## Verification
The bench targets the boundary between the count's last non-negative value and -1. An off-by-one there would fetch one burst too many or close the line one wakeup early. It also covers the zero-burst line (next count -1), where a design that fetched before testing the reloaded count would issue a stray request. Channels are interleaved, and base addresses carry nonzero low bits, so a design that clears the ID bits at line end, lets them leak into `req_addr`, or writes another channel's bank shows up as a wrong address. Bad wakeups are raised on channels in a scattered order so that an XOR or a shifted bit index in `bad_status` is seen.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int NCH = 4;

  typedef enum logic [2:0] {
    ACT_FETCH,
    ACT_LINE_END,
    ACT_BAD_WAKE,
    ACT_NEW_FETCH,
    ACT_NEW_END
  } act_e;

  typedef enum logic [0:0] {
    ST_IDLE,
    ST_REQ
  } st_e;

  localparam logic [1:0] CTL_LINE_DONE = 2'd1;
  localparam logic [1:0] CTL_SHUT_UP   = 2'd2;
endpackage

// File: rtl/sbf_chan_bank.sv
module sbf_chan_bank #(
  parameter int AW  = 20,
  parameter int CW  = 16,
  parameter int BAW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_chan,
  input  logic [CW-1:0]  cfg_next_count,
  input  logic [BAW-1:0] cfg_next_base,
  input  logic           upd_en,
  input  logic [1:0]     upd_chan,
  input  logic [AW-1:0]  upd_addr,
  input  logic [CW-1:0]  upd_count,
  input  logic           upd_base_we,
  input  logic [BAW-1:0] upd_base,
  input  logic [1:0]     rd_chan,
  output logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_count,
  output logic [BAW-1:0] rd_base,
  output logic [CW-1:0]  rd_next_count,
  output logic [BAW-1:0] rd_next_base
);
  import sbf_pkg::*;

  logic [AW-1:0]  addr_q  [NCH];
  logic [CW-1:0]  count_q [NCH];
  logic [BAW-1:0] base_q  [NCH];
  logic [CW-1:0]  ncnt_q  [NCH];
  logic [BAW-1:0] nbase_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [1:0]    ID       = 2'(c);
    localparam logic [AW-1:0] RST_ADDR = {1'b1, {(AW-3){1'b0}}, ID};

    logic hit_upd, hit_cfg;
    assign hit_upd = upd_en && (upd_chan == ID);
    assign hit_cfg = cfg_we && (cfg_chan == ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[c]  <= RST_ADDR;
        count_q[c] <= '1;
        base_q[c]  <= '0;
      end else if (hit_upd) begin
        addr_q[c]  <= upd_addr;
        count_q[c] <= upd_count;
        if (upd_base_we) base_q[c] <= upd_base;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ncnt_q[c]  <= '1;
        nbase_q[c] <= '0;
      end else if (hit_cfg) begin
        ncnt_q[c]  <= cfg_next_count;
        nbase_q[c] <= cfg_next_base;
      end
    end

    AST_ID_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q[c][1:0] == ID); // R7
  end

  assign rd_addr       = addr_q[rd_chan];
  assign rd_count      = count_q[rd_chan];
  assign rd_base       = base_q[rd_chan];
  assign rd_next_count = ncnt_q[rd_chan];
  assign rd_next_base  = nbase_q[rd_chan];
endmodule

// File: rtl/sbf_decide.sv
module sbf_decide #(
  parameter int AW  = 20,
  parameter int CW  = 16,
  parameter int BAW = 32,
  parameter int BW  = 16
) (
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   count,
  input  logic [BAW-1:0]  base,
  input  logic [CW-1:0]   next_count,
  input  logic [BAW-1:0]  next_base,
  output sbf_pkg::act_e   act,
  output logic [AW-1:0]   new_addr,
  output logic [CW-1:0]   new_count,
  output logic            new_base_we,
  output logic [BAW-1:0]  fetch_addr
);
  import sbf_pkg::*;

  localparam int            OW   = AW - 1;
  localparam logic [OW-1:0] STEP = OW'(BW);

  logic          flag;
  logic [OW-1:0] off, off_clean;
  logic [OW-1:0] id_only;

  assign flag      = addr[AW-1];
  assign off       = addr[OW-1:0];
  assign off_clean = {off[OW-1:2], 2'b00};
  assign id_only   = {{(OW-2){1'b0}}, addr[1:0]};

  always_comb begin
    act         = ACT_FETCH;
    new_addr    = addr;
    new_count   = count - 1'b1;
    new_base_we = 1'b0;
    fetch_addr  = base + BAW'(off_clean);
    if (!count[CW-1]) begin
      act      = ACT_FETCH;
      new_addr = {flag, off + STEP};
    end else if (!flag) begin
      act      = ACT_LINE_END;
      new_addr = {1'b1, off};
    end else begin
      new_count = next_count;
      if (next_base == '0) begin
        act = ACT_BAD_WAKE;
      end else begin
        new_base_we = 1'b1;
        new_count   = next_count - 1'b1;
        fetch_addr  = next_base;
        if (!next_count[CW-1]) begin
          act      = ACT_NEW_FETCH;
          new_addr = {1'b0, id_only + STEP};
        end else begin
          act      = ACT_NEW_END;
          new_addr = {1'b1, id_only};
        end
      end
    end
  end
endmodule

// File: rtl/sbf_holdoff.sv
module sbf_holdoff #(
  parameter int GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int HW = $clog2(GAP + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = HW'(GAP);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_HOLD_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
endmodule

// File: rtl/scanline_burst_fetcher.sv
module scanline_burst_fetcher #(
  parameter int AW  = 20,
  parameter int CW  = 16,
  parameter int BAW = 32,
  parameter int BW  = 16,
  parameter int GAP = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wake_valid,
  input  logic [1:0]     wake_chan,
  output logic           wake_ready,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_chan,
  input  logic [CW-1:0]  cfg_next_count,
  input  logic [BAW-1:0] cfg_next_base,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [BAW-1:0] req_addr,
  output logic           ctl_valid,
  output logic [1:0]     ctl_chan,
  output logic [1:0]     ctl_code,
  output logic [3:0]     bad_status
);
  import sbf_pkg::*;

  st_e            st_q, st_d;
  logic           req_valid_q, req_valid_d;
  logic [BAW-1:0] req_addr_q, req_addr_d;
  logic           ctl_valid_q, ctl_valid_d;
  logic [1:0]     ctl_chan_q, ctl_chan_d, ctl_code_q, ctl_code_d;
  logic [3:0]     bad_q, bad_d;
  logic           accept, hold_start, hold_busy, addr_load;

  logic [AW-1:0]  rd_addr, new_addr;
  logic [CW-1:0]  rd_count, rd_ncnt, new_count;
  logic [BAW-1:0] rd_base, rd_nbase, fetch_addr;
  logic           new_base_we;
  act_e           act;

  assign wake_ready = (st_q == ST_IDLE) && !hold_busy;
  assign accept     = wake_valid && wake_ready;

  sbf_chan_bank #(.AW(AW), .CW(CW), .BAW(BAW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_next_count(cfg_next_count), .cfg_next_base(cfg_next_base),
    .upd_en(accept), .upd_chan(wake_chan), .upd_addr(new_addr),
    .upd_count(new_count), .upd_base_we(new_base_we), .upd_base(rd_nbase),
    .rd_chan(wake_chan), .rd_addr(rd_addr), .rd_count(rd_count),
    .rd_base(rd_base), .rd_next_count(rd_ncnt), .rd_next_base(rd_nbase)
  );

  sbf_decide #(.AW(AW), .CW(CW), .BAW(BAW), .BW(BW)) u_decide (
    .addr(rd_addr), .count(rd_count), .base(rd_base),
    .next_count(rd_ncnt), .next_base(rd_nbase),
    .act(act), .new_addr(new_addr), .new_count(new_count),
    .new_base_we(new_base_we), .fetch_addr(fetch_addr)
  );

  sbf_holdoff #(.GAP(GAP)) u_hold (
    .clk(clk), .rst_n(rst_n), .start(hold_start), .busy(hold_busy)
  );

  always_comb begin
    st_d        = st_q;
    req_valid_d = req_valid_q;
    req_addr_d  = req_addr_q;
    ctl_valid_d = 1'b0;
    ctl_chan_d  = ctl_chan_q;
    ctl_code_d  = ctl_code_q;
    bad_d       = bad_q;
    hold_start  = 1'b0;
    addr_load   = 1'b0;
    if (st_q == ST_REQ) begin
      if (req_ready) begin
        st_d        = ST_IDLE;
        req_valid_d = 1'b0;
        hold_start  = 1'b1;
      end
    end else if (accept) begin
      unique case (act)
        ACT_FETCH, ACT_NEW_FETCH: begin
          st_d        = ST_REQ;
          req_valid_d = 1'b1;
          req_addr_d  = fetch_addr;
          addr_load   = 1'b1;
        end
        ACT_LINE_END, ACT_NEW_END: begin
          ctl_valid_d = 1'b1;
          ctl_code_d  = CTL_LINE_DONE;
          ctl_chan_d  = wake_chan;
          hold_start  = 1'b1;
        end
        default: begin
          ctl_valid_d       = 1'b1;
          ctl_code_d        = CTL_SHUT_UP;
          ctl_chan_d        = wake_chan;
          bad_d[wake_chan]  = 1'b1;
          hold_start        = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      req_valid_q <= 1'b0;
      ctl_valid_q <= 1'b0;
      ctl_chan_q  <= '0;
      ctl_code_q  <= '0;
      bad_q       <= '0;
    end else begin
      st_q        <= st_d;
      req_valid_q <= req_valid_d;
      ctl_valid_q <= ctl_valid_d;
      ctl_chan_q  <= ctl_chan_d;
      ctl_code_q  <= ctl_code_d;
      bad_q       <= bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_addr_q <= '0;
    else if (addr_load) req_addr_q <= req_addr_d;
  end

  assign req_valid  = req_valid_q;
  assign req_addr   = req_addr_q;
  assign ctl_valid  = ctl_valid_q;
  assign ctl_chan   = ctl_chan_q;
  assign ctl_code   = ctl_code_q;
  assign bad_status = bad_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R8
  AST_NO_WAKE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !wake_ready); // R8
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bad_status) & ~bad_status) == 4'b0000); // R6
  AST_CTL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && ctl_valid)); // R3
  AST_CTL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid && !wake_ready); // R9
endmodule

// File: tb/sim_scanline_burst_fetcher.sv
module sim_scanline_burst_fetcher;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 20;
  localparam int CW  = 16;
  localparam int BAW = 32;
  localparam int BW  = 16;
  localparam int GAP = 5;
  localparam int OW  = AW - 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wake_valid, wake_ready;
  logic [1:0]     wake_chan;
  logic           cfg_we;
  logic [1:0]     cfg_chan;
  logic [CW-1:0]  cfg_next_count;
  logic [BAW-1:0] cfg_next_base;
  logic           req_valid, req_ready;
  logic [BAW-1:0] req_addr;
  logic           ctl_valid;
  logic [1:0]     ctl_chan, ctl_code;
  logic [3:0]     bad_status;

  scanline_burst_fetcher #(.AW(AW), .CW(CW), .BAW(BAW), .BW(BW), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_valid(wake_valid), .wake_chan(wake_chan),
    .wake_ready(wake_ready), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_next_count(cfg_next_count), .cfg_next_base(cfg_next_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .ctl_valid(ctl_valid), .ctl_chan(ctl_chan), .ctl_code(ctl_code),
    .bad_status(bad_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [OW-1:0]  m_off   [4];
  logic           m_flag  [4];
  logic [CW-1:0]  m_cnt   [4];
  logic [BAW-1:0] m_base  [4];
  logic [CW-1:0]  m_ncnt  [4];
  logic [BAW-1:0] m_nbase [4];
  logic [3:0]     m_bad;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic check_holdoff(input string tag);
    for (int i = 0; i < GAP; i++) begin
      chk(tag, wake_ready, 0);
      @(negedge clk);
    end
    chk(tag, wake_ready, 1);
  endtask

  task automatic cfg(input int ch, input logic [CW-1:0] nc, input logic [BAW-1:0] nb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_next_count = nc; cfg_next_base = nb;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ncnt[ch]  = nc;
    m_nbase[ch] = nb;
  endtask

  // kind: 0 fetch, 1 line done, 2 bad wake
  task automatic wake(input int ch, input int stall);
    int kind;
    string tag;
    logic [BAW-1:0] ea;
    kind = 0; ea = '0; tag = "R2";
    if (!m_cnt[ch][CW-1]) begin
      ea = m_base[ch] + BAW'({m_off[ch][OW-1:2], 2'b00});
      m_off[ch] = m_off[ch] + OW'(BW);
      m_cnt[ch] = m_cnt[ch] - 1'b1;
    end else if (!m_flag[ch]) begin
      kind = 1; tag = "R3";
      m_flag[ch] = 1'b1;
      m_cnt[ch] = m_cnt[ch] - 1'b1;
    end else begin
      m_cnt[ch] = m_ncnt[ch];
      if (m_nbase[ch] == '0) begin
        kind = 2; tag = "R6";
        m_bad[ch] = 1'b1;
      end else begin
        m_base[ch] = m_nbase[ch];
        m_cnt[ch]  = m_ncnt[ch] - 1'b1;
        if (!m_ncnt[ch][CW-1]) begin
          tag = "R4";
          ea = m_base[ch];
          m_flag[ch] = 1'b0;
          m_off[ch] = OW'(ch) + OW'(BW);
        end else begin
          kind = 1; tag = "R5";
          m_flag[ch] = 1'b1;
          m_off[ch] = OW'(ch);
        end
      end
    end
    @(negedge clk);
    chk("R9 ready before wake", wake_ready, 1);
    wake_valid = 1'b1; wake_chan = 2'(ch);
    @(negedge clk);
    wake_valid = 1'b0;
    if (kind == 0) begin
      chk({tag, " req_valid"}, req_valid, 1);
      chk({tag, " R7 R10 req_addr"}, req_addr, ea);
      chk({tag, " no ctl"}, ctl_valid, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R8 held valid", req_valid, 1);
        chk("R8 held addr", req_addr, ea);
        chk("R8 no wake", wake_ready, 0);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      chk("R8 drop after handshake", req_valid, 0);
      check_holdoff("R9 after fetch");
    end else begin
      chk({tag, " ctl_valid"}, ctl_valid, 1);
      chk({tag, " ctl_code"}, ctl_code, (kind == 1) ? 1 : 2);
      chk({tag, " ctl_chan"}, ctl_chan, ch);
      chk({tag, " no req"}, req_valid, 0);
      chk({tag, " bad_status"}, bad_status, m_bad);
      check_holdoff("R9 after ctl");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wake_valid = 1'b0; wake_chan = '0; cfg_we = 1'b0;
    cfg_chan = '0; cfg_next_count = '0; cfg_next_base = '0; req_ready = 1'b0;
    for (int c = 0; c < 4; c++) begin
      m_off[c] = OW'(c); m_flag[c] = 1'b1; m_cnt[c] = '1; m_base[c] = '0;
      m_ncnt[c] = '1; m_nbase[c] = '0;
    end
    m_bad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wake_ready", wake_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 ctl_valid", ctl_valid, 0);
    chk("R1 bad_status", bad_status, 0);

    // R1 R6: first wakeups hit a zero next base, scattered order
    wake(3, 0);
    wake(1, 0);
    wake(0, 0);
    wake(2, 0);
    wake(3, 0);

    // R2 R3 R4 R5 R10: interleaved line sweeps with varied counts
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c < 4; c++)
        cfg(c, CW'(t + c - 2), BAW'(32'h0001_0000 * (c + 1) + t * 32'h100 + c + 1));
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 4; c++)
          wake(c, (r + c + t) % 3);
    end

    // R6 R10: one channel loses its buffer mid-stream, others continue
    cfg(2, CW'(1), '0);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 4; c++)
        wake(c, r % 2);

    report();
    $finish;
  end
endmodule